// File: doc/BRIEF.md
# Keypad-Selected Persistent Page Register

This block turns a press on a small matrix keypad into a page number for an image memory and keeps that choice across power cycles. It strobes the keypad rows one after another and watches the column lines. A key is recognised from the row being strobed and the column that answers. The key number becomes the page number, which drives the upper address lines of the image memory. Each newly chosen page is also saved to an external nonvolatile store.

After every reset the block first reads the saved page back from the store and puts it on the page outputs. Only then does it start scanning, so the image chosen last reappears without any key being touched. The store is reached through a level request that is held until a one-cycle acknowledge. One request line, a write-enable qualifier and a data path run in each direction.

A press counts only when the same single key is seen on several whole scans in a row. After a press is accepted, the keypad must be seen fully released before another press can count. Ambiguous readings with more than one key closed are discarded. Writes go out only when the page really changes. Presses that arrive while a write is waiting for its acknowledge are dropped.

Top module: `kpad_page_keeper`

## Requirements
- R1: While scanning, exactly one row output is high and all others are low. The high row steps row 0, 1, 2, 3, then back to 0, and each row stays high for DWELL (default 4) clock cycles. This timing does not depend on the page shown.
- R2: The key code is row index times COLS plus column index, with COLS = 4 and column bit c of col_sense meaning column c. After a press is accepted, page_sel equals that key code (identity mapping onto 4 bits).
- R3: A key is accepted only after CONFIRM (default 3) consecutive whole scans each contain exactly that one key. A key held for fewer scans leaves page_sel unchanged.
- R4: Once a key is accepted, no further key is accepted until one whole scan has been seen with every column inactive.
- R5: A scan that shows more than one active column, whether in one row or across rows, is discarded. It does not change page_sel, it does not issue a write, and it breaks the run of matching scans.
- R6: If an accepted page differs from the value held in the store, exactly one write is issued (nv_req=1, nv_we=1) with nv_wdata equal to the new page. If it equals the stored value, no write is issued.
- R7: While a write request waits for nv_ack, key presses are ignored. page_sel stays the same, and any partly counted run of matching scans is cleared.
- R8: During reset and until the restore read is acknowledged, page_sel is 0 and every row output is low. The first request after reset is a read (nv_req=1, nv_we=0). On its acknowledge, page_sel takes nv_rdata, and scanning starts after that. The restore issues no write.
- R9: Once nv_req is raised, nv_req, nv_we and nv_wdata stay unchanged until the cycle in which nv_ack is high. nv_req falls in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_drive | output | ROWS | Row strobes, one high at a time while scanning |
| col_sense | input | COLS | Column sense lines, high when a closed key connects the strobed row |
| page_sel | output | PAGE_W | Page number to the upper address lines of the image memory |
| nv_req | output | 1 | Store request, held until acknowledged |
| nv_we | output | 1 | Qualifies nv_req: 1 write, 0 read |
| nv_wdata | output | PAGE_W | Page value to be written |
| nv_ack | input | 1 | One-cycle acknowledge from the store |
| nv_rdata | input | PAGE_W | Stored page, valid while nv_ack is high for a read |

## Verification
The two events that can land together are the acknowledge that ends a pending write and the completion of a scan that holds a newly pressed key. The question is whether that scan is counted toward acceptance. The bench provokes this by making the store slow, accepting one key, releasing it, and then holding a second key across the acknowledge. The result is judged at the ports: page_sel must still show the first page in the acknowledge cycle, and it must reach the second key only after further whole scans. The store must receive exactly one extra write holding the second page.

// File: rtl/kpp_pkg.sv
package kpp_pkg;

   typedef enum logic [1:0] {
      NV_START = 2'd0,
      NV_READ  = 2'd1,
      NV_IDLE  = 2'd2,
      NV_WRITE = 2'd3
   } nv_state_t;

   typedef enum logic [1:0] {
      SCAN_EMPTY  = 2'd0,
      SCAN_SINGLE = 2'd1,
      SCAN_MULTI  = 2'd2
   } scan_kind_t;

   // bits needed to index n items, never below one
   function automatic int unsigned width_for(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/kpp_sync.sv
module kpp_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] pipe [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end

         assign q = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/kpp_scanner.sv
module kpp_scanner
   import kpp_pkg::*;
#(
   parameter int unsigned ROWS  = 4,
   parameter int unsigned COLS  = 4,
   parameter int unsigned DWELL = 4,
   localparam int unsigned ROW_W = width_for(ROWS),
   localparam int unsigned DW_W  = width_for(DWELL),
   localparam int unsigned KEY_W = width_for(ROWS * COLS),
   localparam int unsigned CI_W  = width_for(COLS),
   localparam int unsigned CN_W  = width_for(COLS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [COLS-1:0]  col_s,
   output logic [ROWS-1:0]  row_drive,
   output logic             scan_done,
   output scan_kind_t       scan_kind,
   output logic [KEY_W-1:0] scan_key
);

   logic [ROW_W-1:0] row_idx;
   logic [DW_W-1:0]  dwell_cnt;
   logic             sample;
   logic             last_row;

   assign sample   = enable && (dwell_cnt == DW_W'(DWELL - 1));
   assign last_row = (row_idx == ROW_W'(ROWS - 1));

   // row / dwell timing, free running while enabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_idx   <= '0;
         dwell_cnt <= '0;
      end else if (!enable) begin
         row_idx   <= '0;
         dwell_cnt <= '0;
      end else if (sample) begin
         dwell_cnt <= '0;
         row_idx   <= last_row ? '0 : row_idx + 1'b1;
      end else begin
         dwell_cnt <= dwell_cnt + 1'b1;
      end
   end

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         assign row_drive[r] = enable && (row_idx == ROW_W'(r));
      end
   endgenerate

   // column analysis for the row being sampled
   logic [CN_W-1:0]  hit_cnt;
   logic [CI_W-1:0]  hit_col;
   logic [KEY_W-1:0] row_key;

   always_comb begin
      hit_cnt = '0;
      hit_col = '0;
      for (int c = COLS - 1; c >= 0; c--) begin
         if (col_s[c]) begin
            hit_cnt = hit_cnt + 1'b1;
            hit_col = CI_W'(c);
         end
      end
   end

   assign row_key = KEY_W'(row_idx) * KEY_W'(COLS) + KEY_W'(hit_col);

   // whole-scan accumulation
   logic             seen_one, seen_many;
   logic [KEY_W-1:0] acc_key;
   logic             nxt_one, nxt_many;
   logic [KEY_W-1:0] nxt_key;

   always_comb begin
      nxt_one  = seen_one;
      nxt_many = seen_many;
      nxt_key  = acc_key;
      if ((hit_cnt > CN_W'(1)) || ((hit_cnt == CN_W'(1)) && seen_one)) begin
         nxt_many = 1'b1;
      end else if (hit_cnt == CN_W'(1)) begin
         nxt_one = 1'b1;
         nxt_key = row_key;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_one  <= 1'b0;
         seen_many <= 1'b0;
         acc_key   <= '0;
      end else if (!enable) begin
         seen_one  <= 1'b0;
         seen_many <= 1'b0;
         acc_key   <= '0;
      end else if (sample) begin
         if (last_row) begin
            seen_one  <= 1'b0;
            seen_many <= 1'b0;
            acc_key   <= '0;
         end else begin
            seen_one  <= nxt_one;
            seen_many <= nxt_many;
            acc_key   <= nxt_key;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_done <= 1'b0;
         scan_kind <= SCAN_EMPTY;
         scan_key  <= '0;
      end else begin
         scan_done <= sample && last_row;
         if (sample && last_row) begin
            scan_key  <= nxt_key;
            scan_kind <= nxt_many ? SCAN_MULTI :
                         nxt_one  ? SCAN_SINGLE : SCAN_EMPTY;
         end
      end
   end

endmodule

// File: rtl/kpp_qualifier.sv
module kpp_qualifier
   import kpp_pkg::*;
#(
   parameter int unsigned KEY_W   = 4,
   parameter int unsigned CONFIRM = 3,
   localparam int unsigned CNT_W  = width_for(CONFIRM + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scan_done,
   input  scan_kind_t       scan_kind,
   input  logic [KEY_W-1:0] scan_key,
   input  logic             blocked,
   output logic             accept,
   output logic [KEY_W-1:0] accept_key
);

   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] next_cnt;
   logic [KEY_W-1:0] last_key;
   logic             armed;

   assign next_cnt = ((run_cnt != '0) && (scan_key == last_key)) ?
                     run_cnt + 1'b1 : CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt    <= '0;
         last_key   <= '0;
         armed      <= 1'b1;
         accept     <= 1'b0;
         accept_key <= '0;
      end else begin
         accept <= 1'b0;
         if (scan_done) begin
            unique case (scan_kind)
               SCAN_EMPTY: begin
                  run_cnt <= '0;
                  armed   <= 1'b1;
               end
               SCAN_SINGLE: begin
                  if (blocked || !armed) begin
                     run_cnt <= '0;
                  end else if (next_cnt == CNT_W'(CONFIRM)) begin
                     accept     <= 1'b1;
                     accept_key <= scan_key;
                     armed      <= 1'b0;
                     run_cnt    <= '0;
                  end else begin
                     run_cnt  <= next_cnt;
                     last_key <= scan_key;
                  end
               end
               default: begin
                  run_cnt <= '0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/kpp_nv_ctrl.sv
module kpp_nv_ctrl
   import kpp_pkg::*;
#(
   parameter int unsigned PAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [PAGE_W-1:0] accept_page,
   input  logic              nv_ack,
   input  logic [PAGE_W-1:0] nv_rdata,
   output logic              nv_req,
   output logic              nv_we,
   output logic [PAGE_W-1:0] nv_wdata,
   output logic [PAGE_W-1:0] page_sel,
   output logic              scan_en,
   output logic              busy
);

   nv_state_t         state;
   logic [PAGE_W-1:0] stored;
   logic [PAGE_W-1:0] page_q;
   logic [PAGE_W-1:0] wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= NV_START;
         stored  <= '0;
         page_q  <= '0;
         wdata_q <= '0;
      end else begin
         case (state)
            NV_START: state <= NV_READ;
            NV_READ: begin
               if (nv_ack) begin
                  page_q <= nv_rdata;
                  stored <= nv_rdata;
                  state  <= NV_IDLE;
               end
            end
            NV_IDLE: begin
               if (accept) begin
                  page_q <= accept_page;
                  if (accept_page != stored) begin
                     wdata_q <= accept_page;
                     state   <= NV_WRITE;
                  end
               end
            end
            NV_WRITE: begin
               if (nv_ack) begin
                  stored <= wdata_q;
                  state  <= NV_IDLE;
               end
            end
            default: state <= NV_START;
         endcase
      end
   end

   assign nv_req   = (state == NV_READ) || (state == NV_WRITE);
   assign nv_we    = (state == NV_WRITE);
   assign nv_wdata = wdata_q;
   assign page_sel = page_q;
   assign scan_en  = (state == NV_IDLE) || (state == NV_WRITE);
   assign busy     = (state == NV_WRITE);

endmodule

// File: rtl/kpad_page_keeper.sv
module kpad_page_keeper
   import kpp_pkg::*;
#(
   parameter int unsigned ROWS        = 4,
   parameter int unsigned COLS        = 4,
   parameter int unsigned PAGE_W      = 4,
   parameter int unsigned DWELL       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CONFIRM     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ROWS-1:0]   row_drive,
   input  logic [COLS-1:0]   col_sense,
   output logic [PAGE_W-1:0] page_sel,
   output logic              nv_req,
   output logic              nv_we,
   output logic [PAGE_W-1:0] nv_wdata,
   input  logic              nv_ack,
   input  logic [PAGE_W-1:0] nv_rdata
);

   localparam int unsigned KEY_W = width_for(ROWS * COLS);

   generate
      if (ROWS < 2 || COLS < 2) begin : g_bad_matrix
         $error("keypad needs at least two rows and two columns");
      end
      if (DWELL <= SYNC_STAGES) begin : g_bad_dwell
         $error("row dwell must exceed the column synchroniser depth");
      end
      if (ROWS * COLS > (1 << PAGE_W)) begin : g_bad_page
         $error("page width too narrow for every key code");
      end
      if (CONFIRM < 1) begin : g_bad_confirm
         $error("confirmation count must be at least one");
      end
   endgenerate

   logic [COLS-1:0]  col_s;
   logic             scan_en;
   logic             busy;
   logic             scan_done;
   scan_kind_t       scan_kind;
   logic [KEY_W-1:0] scan_key;
   logic             accept;
   logic [KEY_W-1:0] accept_key;

   kpp_sync #(.WIDTH(COLS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (col_sense),
      .q     (col_s)
   );

   kpp_scanner #(.ROWS(ROWS), .COLS(COLS), .DWELL(DWELL)) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (scan_en),
      .col_s     (col_s),
      .row_drive (row_drive),
      .scan_done (scan_done),
      .scan_kind (scan_kind),
      .scan_key  (scan_key)
   );

   kpp_qualifier #(.KEY_W(KEY_W), .CONFIRM(CONFIRM)) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .scan_done  (scan_done),
      .scan_kind  (scan_kind),
      .scan_key   (scan_key),
      .blocked    (busy),
      .accept     (accept),
      .accept_key (accept_key)
   );

   kpp_nv_ctrl #(.PAGE_W(PAGE_W)) u_nv (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .accept_page (PAGE_W'(accept_key)),
      .nv_ack      (nv_ack),
      .nv_rdata    (nv_rdata),
      .nv_req      (nv_req),
      .nv_we       (nv_we),
      .nv_wdata    (nv_wdata),
      .page_sel    (page_sel),
      .scan_en     (scan_en),
      .busy        (busy)
   );

endmodule

// File: rtl/kpp_checker.sv
module kpp_checker #(
   parameter int unsigned ROWS   = 4,
   parameter int unsigned PAGE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ROWS-1:0]   row_drive,
   input logic [PAGE_W-1:0] page_sel,
   input logic              nv_req,
   input logic              nv_we,
   input logic [PAGE_W-1:0] nv_wdata,
   input logic              nv_ack
);

   assert_row_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_drive));

   assert_row_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(row_drive) != '0 && row_drive != '0 && row_drive != $past(row_drive))
      |-> row_drive == {$past(row_drive[ROWS-2:0]), $past(row_drive[ROWS-1])});

   assert_page_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (page_sel != $past(page_sel))
      |-> ($past(nv_req && !nv_we && nv_ack) || (nv_req && nv_we && !$past(nv_req))));

   assert_wdata_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_req && nv_we) |-> (nv_wdata == page_sel));

   assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_req && nv_we && !nv_ack) |=> $stable(page_sel));

   assert_restore_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_req && !nv_we) |-> (row_drive == '0));

   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_req && !nv_ack) |=> (nv_req && $stable(nv_we) && $stable(nv_wdata)));

   assert_req_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_req && nv_ack) |=> !nv_req);

endmodule

bind kpad_page_keeper kpp_checker #(.ROWS(ROWS), .PAGE_W(PAGE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .row_drive (row_drive),
   .page_sel  (page_sel),
   .nv_req    (nv_req),
   .nv_we     (nv_we),
   .nv_wdata  (nv_wdata),
   .nv_ack    (nv_ack)
);

// File: tb/tb_kpad_page_keeper.sv
`timescale 1ns/1ps
module tb_kpad_page_keeper;

   localparam int ROWS  = 4;
   localparam int COLS  = 4;
   localparam int PW    = 4;
   localparam int DWELL = 4;
   localparam int SCAN  = ROWS * DWELL;
   localparam int WD    = 100000;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [ROWS-1:0] row_drive;
   logic [COLS-1:0] col_sense;
   logic [PW-1:0]   page_sel;
   logic            nv_req, nv_we, nv_ack;
   logic [PW-1:0]   nv_wdata, nv_rdata;

   logic [15:0]     pressed;
   int              nv_lat;
   logic            use_preset;
   logic [PW-1:0]   preset_val;
   logic [PW-1:0]   mem;
   int              lat_cnt;
   int              writes;
   int              proto_err;
   int              total = 0;
   int              bad = 0;

   always #2.5 clk = ~clk;

   kpad_page_keeper dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .row_drive (row_drive),
      .col_sense (col_sense),
      .page_sel  (page_sel),
      .nv_req    (nv_req),
      .nv_we     (nv_we),
      .nv_wdata  (nv_wdata),
      .nv_ack    (nv_ack),
      .nv_rdata  (nv_rdata)
   );

   // keypad: a closed key joins its row strobe to its column line
   always_comb begin
      col_sense = '0;
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            if (pressed[r*COLS+c] && row_drive[r]) col_sense[c] = 1'b1;
   end

   // nonvolatile store model with programmable latency
   assign nv_rdata = mem;
   always @(posedge clk) begin
      if (!rst_n) begin
         nv_ack  <= 1'b0;
         lat_cnt <= 0;
         if (use_preset) mem <= preset_val;
      end else if (nv_ack) begin
         nv_ack  <= 1'b0;
         lat_cnt <= 0;
      end else if (nv_req) begin
         if (lat_cnt >= nv_lat) begin
            nv_ack <= 1'b1;
            if (nv_we) begin
               mem    <= nv_wdata;
               writes <= writes + 1;
            end
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   // request must not be withdrawn before acknowledge
   logic prev_req = 1'b0, prev_ack = 1'b0;
   always @(negedge clk) begin
      if (rst_n && prev_req && !nv_req && !prev_ack) proto_err = proto_err + 1;
      prev_req = nv_req;
      prev_ack = nv_ack;
   end

   task automatic report();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_store_idle();
      while (nv_req) @(negedge clk);
      cycles(2);
   endtask

   task automatic press(input logic [15:0] m, input int scans);
      pressed = m;
      cycles(scans * SCAN);
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
      report();
      $finish;
   end

   // mask, hold scans, expected page, expected new writes
   localparam logic [25:0] VEC [9] = '{
      {16'h0020, 4'd5, 4'd5,  2'd1},
      {16'h0020, 4'd5, 4'd5,  2'd0},
      {16'h4000, 4'd2, 4'd5,  2'd0},
      {16'h4000, 4'd5, 4'd14, 2'd1},
      {16'h0003, 4'd6, 4'd14, 2'd0},
      {16'h1008, 4'd6, 4'd14, 2'd0},
      {16'h0001, 4'd5, 4'd0,  2'd1},
      {16'h8000, 4'd5, 4'd15, 2'd1},
      {16'h0200, 4'd5, 4'd9,  2'd1}
   };
   string vtag [9] = '{"R2", "R6", "R3", "R2", "R5", "R5", "R2", "R2", "R6"};

   initial begin
      int w0;
      logic [ROWS-1:0] prev;
      int run, changes, onehot_err, order_err, run_err;
      rst_n = 1'b0; pressed = '0; nv_lat = 40; use_preset = 1'b1;
      preset_val = 4'd9; writes = 0; proto_err = 0;
      cycles(3);
      check("R8 page in reset", page_sel, 0);
      check("R8 no request in reset", nv_req, 0);
      check("R8 rows low in reset", row_drive, 0);
      rst_n = 1'b1;
      cycles(6);
      check("R8 read requested", {nv_req, nv_we}, 2'b10);
      check("R8 page before restore", page_sel, 0);
      check("R8 rows low during restore", row_drive, 0);
      wait_store_idle();
      check("R8 restored page", page_sel, 9);
      check("R8 restore writes nothing", writes, 0);
      nv_lat = 4;

      // R1 row sequence and dwell
      prev = row_drive; run = 0; changes = 0;
      onehot_err = 0; order_err = 0; run_err = 0;
      for (int i = 0; i < 4 * SCAN; i++) begin
         cycles(1);
         if ($countones(row_drive) != 1) onehot_err++;
         if (row_drive != prev) begin
            if (row_drive != {prev[ROWS-2:0], prev[ROWS-1]}) order_err++;
            if (changes > 0 && run != DWELL) run_err++;
            changes++;
            run = 1;
         end else begin
            run++;
         end
         prev = row_drive;
      end
      check("R1 one row high", onehot_err, 0);
      check("R1 row order", order_err, 0);
      check("R1 row dwell", run_err, 0);
      check("R1 steps seen", changes >= 12, 1);

      // table of vectors
      for (int v = 0; v < 9; v++) begin
         w0 = writes;
         press(VEC[v][25:10], int'(VEC[v][9:6]));
         press('0, 3);
         wait_store_idle();
         check({vtag[v], " page"}, page_sel, VEC[v][5:2]);
         check({vtag[v], " write count"}, writes - w0, VEC[v][1:0]);
         check({vtag[v], " stored"}, mem, VEC[v][5:2]);
      end

      // R4 switch keys without a released scan
      press(16'h0008, 5);
      check("R4 first key", page_sel, 3);
      press(16'h0040, 6);
      check("R4 no rearm", page_sel, 3);
      press('0, 3);
      press(16'h0040, 5);
      press('0, 3);
      wait_store_idle();
      check("R4 after release", page_sel, 6);

      // R7 presses while a write waits
      nv_lat = 300;
      w0 = writes;
      press(16'h0004, 5);
      press('0, 3);
      press(16'h0400, 5);
      press('0, 1);
      check("R7 write pending", {nv_req, nv_we}, 2'b11);
      check("R7 page held", page_sel, 2);
      wait_store_idle();
      check("R7 page after ack", page_sel, 2);
      check("R7 single write", writes - w0, 1);
      check("R7 stored", mem, 2);

      // ack and a held key meet
      nv_lat = 150;
      w0 = writes;
      press(16'h0800, 5);
      press('0, 3);
      pressed = 16'h2000;
      while (nv_req) @(negedge clk);
      check("R7 page at ack", page_sel, 11);
      cycles(5 * SCAN);
      check("R3 counted after ack", page_sel, 13);
      press('0, 2);
      wait_store_idle();
      check("R6 writes across ack", writes - w0, 2);
      check("R6 stored after ack", mem, 13);

      // restore of a written value
      nv_lat = 3; use_preset = 1'b0; w0 = writes;
      rst_n = 1'b0;
      cycles(3);
      check("R8 page cleared", page_sel, 0);
      rst_n = 1'b1;
      cycles(1);
      wait_store_idle();
      check("R8 page recalled", page_sel, 13);
      check("R8 no write on recall", writes - w0, 0);
      check("R9 request held", proto_err, 0);

      report();
      $finish;
   end

endmodule